// File: doc/BRIEF.md
# Transfer list descriptor walker

The walker steps through a list of 16-byte entries kept in memory. Each entry is either a transfer or a conditional branch. Starting from an address given with a start pulse, it fetches the words of each entry through a single read port with a request/acknowledge handshake. It then classifies the entry and either hands the transfer fields to the bus protocol engine or evaluates a branch.

For a transfer, the walker holds the fields until the engine reports completion. It then writes the engine's result word into the entry's last word, which is the only word it ever writes. For a branch, it shows the condition word for one cycle and samples a taken flag. A taken branch moves to the jump address, and a branch that is not taken moves to the next entry. A misaligned start address, a misaligned taken jump, or an odd buffer pointer on a transmit transfer stops the walk with an invalid-descriptor flag.

Word 0 carries three control bits: bit 31 marks a branch, bit 30 marks a receive transfer (the core writes data into the buffer), and bit 29 marks the last transfer of the list.

Top module: `lw_list_walker`

## Requirements
- R1: After reset, busy_o, invalid_o, rd_req_o, wr_req_o, xfer_valid_o and cond_valid_o are all low.
- R2: A start pulse whose address has any of bits 3:0 set is rejected. invalid_o rises in the following cycle, busy_o stays low and no read is issued. An accepted start clears invalid_o.
- R3: For every entry, reads go to entry+0 and entry+4, then entry+8 for a transfer only. A request is held with a stable address until acknowledged, and offset 12 is never read.
- R4: For a transfer entry, xfer_valid_o is raised with word 0 and word 1 of the entry and is held until xfer_done_i.
- R5: On a receive transfer (word 0 bit 30 set) whose pointer has bit 0 set, xfer_discard_o is high. xfer_ptr_o always shows the pointer with bit 0 cleared.
- R6: A transmit transfer (word 0 bit 30 clear) whose pointer has bit 0 set halts the walk with invalid_o high. It is never presented and nothing is written.
- R7: After xfer_done_i, exactly one write of xfer_result_i goes to entry+12. No other address is ever written.
- R8: After the result write of a transfer with word 0 bit 29 set, busy_o falls with invalid_o low.
- R9: A branch (word 0 bit 31 set) that is taken, with a jump address whose bits 3:0 are zero, continues at the jump address, which is word 1.
- R10: A branch that is not taken continues at entry+16, whatever its jump address holds.
- R11: A taken branch whose jump address has any of bits 3:0 set halts the walk with invalid_o high, and no further entry is read.
- R12: A start pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (used only when idle) |
| start_addr_i | input | ADDR_W | Byte address of the first entry |
| busy_o | output | 1 | Walk in progress |
| invalid_o | output | 1 | Last walk stopped on an invalid descriptor |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DATA_W | Read data |
| wr_req_o | output | 1 | Write request (result word) |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | DATA_W | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| xfer_valid_o | output | 1 | Transfer fields valid |
| xfer_w0_o | output | DATA_W | Transfer word 0 |
| xfer_w1_o | output | DATA_W | Transfer word 1 |
| xfer_ptr_o | output | DATA_W | Buffer pointer, bit 0 cleared |
| xfer_discard_o | output | 1 | Received data is to be dropped |
| xfer_done_i | input | 1 | Engine finished the transfer |
| xfer_result_i | input | DATA_W | Result word to write back |
| cond_valid_o | output | 1 | Branch condition presented |
| cond_word_o | output | DATA_W | Branch condition word |
| taken_i | input | 1 | Branch taken, sampled while cond_valid_o is high |

## Verification
The assertions assume that the memory keeps an acknowledge to cycles where a request is present, that the engine raises xfer_done_i only while xfer_valid_o is high, and that taken_i is meaningful only while cond_valid_o is high. The bench's memory model acknowledges only outstanding requests, either every cycle or every other cycle. Its engine model completes three cycles after the fields appear, and its condition model derives taken_i from bit 0 of the presented condition word. A sweep over branch direction, jump alignment, transfer direction, pointer bit 0 and acknowledge stalling covers every halt and continue path with the same list layout.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_CLS, ST_F2, ST_CHK, ST_XFER, ST_WRES, ST_BR
  } walk_state_e;

  localparam int unsigned ENTRY_BYTES = 16;
  localparam int unsigned RES_OFFSET  = 12;
  localparam int unsigned TYPE_BIT    = 31;
  localparam int unsigned RX_BIT      = 30;
  localparam int unsigned LAST_BIT    = 29;
endpackage

// File: rtl/lw_word_regs.sv
module lw_word_regs #(
  parameter  int NW = 3,
  parameter  int DW = 32,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic [IW-1:0]         idx_i,
  input  logic [DW-1:0]         data_i,
  output logic [NW-1:0][DW-1:0] words_o
);
  for (genvar g = 0; g < NW; g++) begin : g_w
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (cap_i && idx_i == IW'(g))   q <= data_i;
    end
    assign words_o[g] = q;
  end
endmodule

// File: rtl/lw_entry_decode.sv
module lw_entry_decode #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          type_bit_i,
  input  logic          rx_bit_i,
  input  logic          last_bit_i,
  input  logic [AW-1:0] jump_i,
  input  logic [DW-1:0] ptr_i,
  output logic          is_branch_o,
  output logic          is_last_o,
  output logic          discard_o,
  output logic          ptr_bad_o,
  output logic          jump_bad_o,
  output logic [AW-1:0] jump_o,
  output logic [DW-1:0] ptr_o
);
  assign is_branch_o = type_bit_i;
  assign is_last_o   = last_bit_i;
  // odd pointer: discard marker on receive, misalignment on transmit
  assign discard_o   = rx_bit_i & ptr_i[0];
  assign ptr_bad_o   = ~rx_bit_i & ptr_i[0];
  assign jump_bad_o  = |jump_i[3:0];
  assign jump_o      = jump_i;
  assign ptr_o       = {ptr_i[DW-1:1], 1'b0};
endmodule

// File: rtl/lw_addr_gen.sv
module lw_addr_gen
  import lw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] entry_i,
  input  logic [AW-1:0] jump_i,
  input  logic [1:0]    word_i,
  input  logic          take_jump_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] res_addr_o,
  output logic [AW-1:0] next_o
);
  assign rd_addr_o  = entry_i + AW'({word_i, 2'b00});
  assign res_addr_o = entry_i + AW'(RES_OFFSET);
  assign next_o     = take_jump_i ? jump_i : entry_i + AW'(ENTRY_BYTES);
endmodule

// File: rtl/lw_list_walker.sv
module lw_list_walker
  import lw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              busy_o,
  output logic              invalid_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              xfer_valid_o,
  output logic [DATA_W-1:0] xfer_w0_o,
  output logic [DATA_W-1:0] xfer_w1_o,
  output logic [DATA_W-1:0] xfer_ptr_o,
  output logic              xfer_discard_o,
  input  logic              xfer_done_i,
  input  logic [DATA_W-1:0] xfer_result_i,
  output logic              cond_valid_o,
  output logic [DATA_W-1:0] cond_word_o,
  input  logic              taken_i
);
  localparam int NWORDS = 3;

  walk_state_e state_q;
  logic [ADDR_W-1:0] entry_q;
  logic [DATA_W-1:0] result_q;
  logic              invalid_q;
  logic [1:0]        word_idx;
  logic              cap;
  logic [NWORDS-1:0][DATA_W-1:0] words;
  logic is_branch, is_last, discard, ptr_bad, jump_bad;
  logic [ADDR_W-1:0] jump_addr, res_addr, next_addr;
  logic [DATA_W-1:0] ptr_clean;

  always_comb begin
    unique case (state_q)
      ST_F1:   word_idx = 2'd1;
      ST_F2:   word_idx = 2'd2;
      default: word_idx = 2'd0;
    endcase
  end

  assign rd_req_o = (state_q == ST_F0) || (state_q == ST_F1) || (state_q == ST_F2);
  assign cap      = rd_req_o & rd_ack_i;

  lw_word_regs #(.NW(NWORDS), .DW(DATA_W)) u_words (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .idx_i   (word_idx),
    .data_i  (rd_data_i),
    .words_o (words)
  );

  lw_entry_decode #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
    .type_bit_i  (words[0][TYPE_BIT]),
    .rx_bit_i    (words[0][RX_BIT]),
    .last_bit_i  (words[0][LAST_BIT]),
    .jump_i      (words[1][ADDR_W-1:0]),
    .ptr_i       (words[2]),
    .is_branch_o (is_branch),
    .is_last_o   (is_last),
    .discard_o   (discard),
    .ptr_bad_o   (ptr_bad),
    .jump_bad_o  (jump_bad),
    .jump_o      (jump_addr),
    .ptr_o       (ptr_clean)
  );

  lw_addr_gen #(.AW(ADDR_W)) u_addr (
    .entry_i     (entry_q),
    .jump_i      (jump_addr),
    .word_i      (word_idx),
    .take_jump_i ((state_q == ST_BR) && taken_i),
    .rd_addr_o   (rd_addr_o),
    .res_addr_o  (res_addr),
    .next_o      (next_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      entry_q   <= '0;
      result_q  <= '0;
      invalid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (|start_addr_i[3:0]) invalid_q <= 1'b1;
          else begin
            entry_q   <= start_addr_i;
            invalid_q <= 1'b0;
            state_q   <= ST_F0;
          end
        end
        ST_F0:  if (rd_ack_i) state_q <= ST_F1;
        ST_F1:  if (rd_ack_i) state_q <= ST_CLS;
        ST_CLS: state_q <= is_branch ? ST_BR : ST_F2;
        ST_F2:  if (rd_ack_i) state_q <= ST_CHK;
        ST_CHK: begin
          if (ptr_bad) begin
            invalid_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else state_q <= ST_XFER;
        end
        ST_XFER: if (xfer_done_i) begin
          result_q <= xfer_result_i;
          state_q  <= ST_WRES;
        end
        ST_WRES: if (wr_ack_i) begin
          if (is_last) state_q <= ST_IDLE;
          else begin
            entry_q <= next_addr;
            state_q <= ST_F0;
          end
        end
        ST_BR: begin
          if (taken_i && jump_bad) begin
            invalid_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            entry_q <= next_addr;
            state_q <= ST_F0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign invalid_o      = invalid_q;
  assign wr_req_o       = (state_q == ST_WRES);
  assign wr_addr_o      = res_addr;
  assign wr_data_o      = result_q;
  assign xfer_valid_o   = (state_q == ST_XFER);
  assign xfer_w0_o      = words[0];
  assign xfer_w1_o      = words[1];
  assign xfer_ptr_o     = ptr_clean;
  assign xfer_discard_o = discard;
  assign cond_valid_o   = (state_q == ST_BR);
  assign cond_word_o    = words[0];

  AST_ENTRY_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> entry_q[3:0] == 4'h0); // R2
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R3
  AST_RD_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[3:2] != 2'b11); // R3
  AST_DISCARD_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_discard_o |-> xfer_w0_o[RX_BIT]); // R5
  AST_TX_PTR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_w0_o[RX_BIT] |-> !words[2][0]); // R6
  AST_WR_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_addr_o[3:0] == 4'hC); // R7
  AST_WR_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_done_i |=> wr_req_o && wr_data_o == $past(xfer_result_i)); // R7
  AST_BUSY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !invalid_o); // R2
endmodule

// File: tb/sim_lw_list_walker.sv
`timescale 1ns/1ps
module sim_lw_list_walker;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni;
  logic start_i;
  logic [AW-1:0] start_addr_i;
  logic busy_o, invalid_o;
  logic rd_req_o, rd_ack_i;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i;
  logic wr_req_o, wr_ack_i;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic xfer_valid_o, xfer_discard_o, xfer_done_i;
  logic [DW-1:0] xfer_w0_o, xfer_w1_o, xfer_ptr_o, xfer_result_i;
  logic cond_valid_o, taken_i;
  logic [DW-1:0] cond_word_o;

  lw_list_walker #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .busy_o(busy_o), .invalid_o(invalid_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
    .xfer_valid_o(xfer_valid_o), .xfer_w0_o(xfer_w0_o), .xfer_w1_o(xfer_w1_o),
    .xfer_ptr_o(xfer_ptr_o), .xfer_discard_o(xfer_discard_o), .xfer_done_i(xfer_done_i),
    .xfer_result_i(xfer_result_i), .cond_valid_o(cond_valid_o), .cond_word_o(cond_word_o),
    .taken_i(taken_i)
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [64];
  int cyc = 0;
  int reads, reads_c, reads_hi, writes, wbad, nx, xcnt;
  logic [15:0] waddr [4];
  logic [31:0] wdata [4];
  logic [7:0]  xt [4];
  logic        xdisc [4];
  logic [31:0] xptr [4];
  logic [31:0] xw1 [4];
  bit stall = 1'b0;
  int nchk = 0;
  int nerr = 0;

  initial begin
    rd_ack_i = 1'b0; wr_ack_i = 1'b0; rd_data_i = '0;
    xfer_done_i = 1'b0; xfer_result_i = '0; taken_i = 1'b0; xcnt = 0;
  end

  // memory, engine and condition models
  always @(negedge clk) begin
    cyc++;
    rd_ack_i  = rd_req_o && !(stall && (cyc % 2 == 1));
    rd_data_i = mem[rd_addr_o[7:2]];
    if (rd_ack_i) begin
      reads++;
      if (rd_addr_o[3:2] == 2'b11) reads_c++;
      if (rd_addr_o >= 16'h0080) reads_hi++;
    end
    wr_ack_i = wr_req_o && !(stall && (cyc % 2 == 1));
    if (wr_ack_i) begin
      if (writes < 4) begin waddr[writes] = wr_addr_o; wdata[writes] = wr_data_o; end
      writes++;
      if (wr_addr_o[3:0] != 4'hC) wbad++;
      mem[wr_addr_o[7:2]] = wr_data_o;
    end
    taken_i = cond_valid_o && cond_word_o[0];
    if (xfer_valid_o) begin
      if (xcnt == 0 && nx < 4) begin
        xt[nx] = xfer_w0_o[7:0]; xdisc[nx] = xfer_discard_o;
        xptr[nx] = xfer_ptr_o; xw1[nx] = xfer_w1_o; nx++;
      end
      xcnt++;
      xfer_done_i   = (xcnt == 3);
      xfer_result_i = 32'hC0DE_0000 | {24'h0, xfer_w0_o[7:0]};
    end else begin
      xcnt = 0;
      xfer_done_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    reads = 0; reads_c = 0; reads_hi = 0; writes = 0; wbad = 0; nx = 0;
  endtask

  task automatic run_case(input bit tk, input bit jlo, input bit rx, input bit pb, input bit st);
    bit inv_a, inv_exp;
    int exp_nx, exp_reads, n;
    logic [15:0] exp_w2;
    logic [7:0]  exp_t2;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    // A @0x00 transfer
    mem[0] = ({31'h0, rx} << 30) | 32'hA1; mem[1] = 32'h0000_1111; mem[2] = 32'h200 | {31'h0, pb};
    // B @0x10 branch, cond bit 0 = taken
    mem[4] = 32'h8000_0000 | {31'h0, tk}; mem[5] = 32'h40 | (jlo ? 32'h4 : 32'h0);
    mem[6] = 32'hFFFF_FFFF; mem[7] = 32'hFFFF_FFFF;
    // C @0x20, D @0x40 last transfers, E @0x80 trap
    mem[8]  = 32'h2000_00C3; mem[9]  = 32'h1234; mem[10] = 32'h300;
    mem[16] = 32'h2000_00D4; mem[17] = 32'h5678; mem[18] = 32'h400;
    mem[32] = 32'h0000_00E5; mem[34] = 32'h500;
    clear_logs();
    stall = st;
    inv_a   = !rx && pb;
    inv_exp = inv_a || (tk && jlo);
    exp_nx  = inv_a ? 0 : ((tk && jlo) ? 1 : 2);
    exp_reads = inv_a ? 3 : ((tk && jlo) ? 5 : 8);
    exp_w2 = tk ? 16'h004C : 16'h002C;
    exp_t2 = tk ? 8'hD4 : 8'hC3;

    @(negedge clk); start_i = 1'b1; start_addr_i = 16'h0000;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 accepted start busy", {31'h0, busy_o}, 1);
    chk(invalid_o == 1'b0, "R2 invalid cleared on start", {31'h0, invalid_o}, 0);
    start_i = 1'b1; start_addr_i = 16'h0080; // R12 start while busy
    @(negedge clk); start_i = 1'b0;
    n = 0;
    while (busy_o && n < 400) begin @(negedge clk); n++; end
    chk(n < 400, "R8 walk ends", n, 0);
    repeat (2) @(negedge clk);

    chk(invalid_o == inv_exp, inv_a ? "R6 invalid flag" : (tk && jlo ? "R11 invalid flag" : "R8 clean end"),
        {31'h0, invalid_o}, {31'h0, inv_exp});
    chk(nx == exp_nx, "R4 transfers presented", nx, exp_nx);
    chk(writes == exp_nx, "R7 result writes", writes, exp_nx);
    chk(wbad == 0, "R7 only result word written", wbad, 0);
    chk(reads == exp_reads, "R3 word reads", reads, exp_reads);
    chk(reads_c == 0, "R3 offset 12 never read", reads_c, 0);
    chk(reads_hi == 0, "R12 busy start ignored", reads_hi, 0);
    if (exp_nx >= 1) begin
      chk(xt[0] == 8'hA1, "R4 first word 0", {24'h0, xt[0]}, 32'hA1);
      chk(xw1[0] == 32'h1111, "R4 first word 1", xw1[0], 32'h1111);
      chk(xdisc[0] == (rx && pb), "R5 discard", {31'h0, xdisc[0]}, {31'h0, rx && pb});
      chk(xptr[0] == 32'h200, "R5 pointer bit 0 cleared", xptr[0], 32'h200);
      chk(waddr[0] == 16'h000C && wdata[0] == 32'hC0DE_00A1, "R7 first result",
          {waddr[0], wdata[0][15:0]}, {16'h000C, 16'h00A1});
    end
    if (exp_nx == 2) begin
      chk(xt[1] == exp_t2, tk ? "R9 taken target" : "R10 fall through", {24'h0, xt[1]}, {24'h0, exp_t2});
      chk(waddr[1] == exp_w2, "R7 second result address", {16'h0, waddr[1]}, {16'h0, exp_w2});
      chk(wdata[1] == (32'hC0DE_0000 | {24'h0, exp_t2}), "R7 second result data",
          wdata[1], 32'hC0DE_0000 | {24'h0, exp_t2});
      chk(xdisc[1] == 1'b0, "R5 even pointer keeps data", {31'h0, xdisc[1]}, 0);
    end
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; start_addr_i = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    clear_logs();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0 && invalid_o == 1'b0, "R1 busy/invalid", {30'h0, busy_o, invalid_o}, 0);
    chk(rd_req_o == 1'b0 && wr_req_o == 1'b0, "R1 requests", {30'h0, rd_req_o, wr_req_o}, 0);
    chk(xfer_valid_o == 1'b0 && cond_valid_o == 1'b0, "R1 valids",
        {30'h0, xfer_valid_o, cond_valid_o}, 0);

    // R2 misaligned start addresses
    for (int lo = 1; lo < 16; lo += 7) begin
      clear_logs();
      @(negedge clk); start_i = 1'b1; start_addr_i = 16'h0020 | 16'(lo);
      @(negedge clk); start_i = 1'b0;
      chk(invalid_o == 1'b1, "R2 misaligned start invalid", {31'h0, invalid_o}, 1);
      chk(busy_o == 1'b0, "R2 misaligned start not busy", {31'h0, busy_o}, 0);
      repeat (5) @(negedge clk);
      chk(reads == 0, "R2 no reads", reads, 0);
    end

    for (int c = 0; c < 32; c++)
      run_case(c[0], c[1], c[2], c[3], c[4]);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule